// File: doc/BRIEF.md
# Distributed Refresh Scheduler with Power-Up Initialisation

This block keeps the contents of an asynchronous DRAM alive. It sits beside the access controller and owns the row strobe, column strobe and write enable lines whenever a refresh runs. The access controller multiplexes these lines onto the memory pins using `ref_active`. In the default variant each refresh is a column-before-row cycle: the column strobe falls first and the device steps its own internal row counter, so no address is driven. A parameter selects a row-only variant instead. In that variant the column strobe stays high and the block drives a row counter on the address lines.

After reset the block keeps the strobes idle for a fixed settling pause. It then issues a fixed number of dummy refresh cycles. Only after that does it raise `host_ready`, which admits host traffic. In normal operation an interval timer makes one refresh due per period. A due refresh is added to a saturating pending count. The block raises `ref_req` to ask the controller to close its page. Refreshes start only while the controller reports idle through `ctrl_idle`, which acts as the grant. While a page stays open, due refreshes pile up to a ceiling. They run back to back once the controller goes idle. All control pins are plain levels; the block carries no data stream, so no valid/ready handshake applies.

Top module: `refresh_sched`

## Requirements
- R1: Out of reset `ras_n`, `cas_n` and `we_n` are high and `host_ready` and `ref_req` are low. No strobe falls during the first INIT_WAIT clock cycles after reset is released.
- R2: After the pause exactly INIT_CYCLES refresh cycles run. `host_ready` stays low until the last of them has finished.
- R3: In a column-before-row refresh `cas_n` falls exactly CSR_CYC cycles before `ras_n` falls.
- R4: In a column-before-row refresh `cas_n` stays low for exactly CHR_CYC cycles after `ras_n` falls, then returns high while `ras_n` is still low.
- R5: `we_n` is high during every refresh cycle, so no refresh is taken as a write.
- R6: `ras_n` stays low for exactly RAS_CYC cycles per refresh. It stays high for at least max(RP_CYC, RC_CYC-RAS_CYC) cycles before the next fall.
- R7: After initialisation, with `ctrl_idle` held high, exactly one refresh starts per INTERVAL cycles.
- R8: While `ctrl_idle` is low no refresh starts. `ref_req` is high whenever refreshes are pending, and `host_ready` stays high.
- R9: The pending count saturates at MAX_PEND. When `ctrl_idle` returns high, exactly that many refreshes run back to back and `ref_req` then drops.
- R10: `host_ready` is low while `ref_active` is high. It is also low in any cycle where refreshes are pending and `ctrl_idle` is high, so refresh wins over a new host request.
- R11: With RAS_ONLY=1, `cas_n` stays high and `ref_addr` carries a row number that starts at 0 and rises by one per refresh (modulo 2^ROW_BITS). With RAS_ONLY=0, `ref_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_idle | input | 1 | Access controller has no open page; grants refresh |
| ref_req | output | 1 | Refreshes are pending; asks the controller to close its page |
| host_ready | output | 1 | Host may start a new access |
| ref_active | output | 1 | Block owns the strobe lines this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ref_addr | output | ROW_BITS | Row number in the row-only variant, zero otherwise |

## Verification
The bench keeps the strobe timing parameters at their defaults. It shrinks INIT_WAIT to 50 cycles and INTERVAL to 200 cycles, so the power-up pause, the periodic cadence and a full twelve-interval page hold that saturates the eight-deep pending count all fit within a short run. The 200-cycle interval is longer than a burst of eight refreshes, so a released backlog can be counted exactly without a fresh tick landing inside it. A second instance built with RAS_ONLY=1 checks the row counter on the address lines and the absence of column strobes.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CSR  = 2'd1,
    ST_RAS  = 2'd2,
    ST_PRE  = 2'd3
  } strobe_st_t;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en)      cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refsched_pending.sv
module refsched_pending #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  localparam int CW = $clog2(MAX + 1);
  localparam logic [CW-1:0] CEIL = CW'(MAX);

  logic [CW-1:0] count_q;
  logic          full;

  assign full    = (count_q == CEIL);
  assign nonzero = (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else begin
      unique case ({inc && !full, dec})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CEIL); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> nonzero); // R9
endmodule

// File: rtl/refsched_strobe.sv
module refsched_strobe
  import refsched_pkg::*;
#(
  parameter int CSR_CYC  = 1,
  parameter int CHR_CYC  = 1,
  parameter int RAS_CYC  = 6,
  parameter int PRE_CYC  = 5,
  parameter bit RAS_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int MAXLEN = (RAS_CYC > PRE_CYC) ?
                          ((RAS_CYC > CSR_CYC) ? RAS_CYC : CSR_CYC) :
                          ((PRE_CYC > CSR_CYC) ? PRE_CYC : CSR_CYC);
  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] CHR_LIM  = CW'(CHR_CYC);

  strobe_st_t   st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          leave;

  always_comb begin
    st_d  = st_q;
    leave = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = RAS_ONLY ? ST_RAS : ST_CSR;
      ST_CSR:  if (cnt_q == CSR_LAST) begin st_d = ST_RAS;  leave = 1'b1; end
      ST_RAS:  if (cnt_q == RAS_LAST) begin st_d = ST_PRE;  leave = 1'b1; end
      ST_PRE:  if (cnt_q == PRE_LAST) begin st_d = ST_IDLE; leave = 1'b1; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (leave || st_q == ST_IDLE) ? '0 : cnt_q + 1'b1;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_PRE) && (cnt_q == PRE_LAST);
  assign ras_n = (st_q != ST_RAS);
  assign cas_n = RAS_ONLY ? 1'b1 :
                 !((st_q == ST_CSR) || (st_q == ST_RAS && cnt_q < CHR_LIM));
  assign we_n  = 1'b1;

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!RAS_ONLY && $fell(ras_n)) |-> (!cas_n && $past(!cas_n))); // R3
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == ST_IDLE)); // R10
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int INIT_WAIT   = 20000,
  parameter int INIT_CYCLES = 8,
  parameter int INTERVAL    = 1560,
  parameter int MAX_PEND    = 8,
  parameter int CSR_CYC     = 1,
  parameter int CHR_CYC     = 1,
  parameter int RAS_CYC     = 6,
  parameter int RP_CYC      = 4,
  parameter int RC_CYC      = 11,
  parameter bit RAS_ONLY    = 1'b0,
  parameter int ROW_BITS    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_idle,
  output logic                ref_req,
  output logic                host_ready,
  output logic                ref_active,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] ref_addr
);
  localparam int PRE_CYC = (RC_CYC - RAS_CYC > RP_CYC) ? (RC_CYC - RAS_CYC) : RP_CYC;
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] INIT_N = IW'(INIT_CYCLES);

  phase_t        phase_q;
  logic [IW-1:0] issued_q;
  logic          wait_tick, int_tick;
  logic          busy, done, pend_nz;
  logic          init_start, run_start, start;

  refsched_timer #(.PERIOD(INIT_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(phase_q == PH_WAIT), .tick(wait_tick)
  );

  refsched_timer #(.PERIOD(INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(phase_q == PH_RUN), .tick(int_tick)
  );

  refsched_pending #(.MAX(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(int_tick), .dec(run_start), .nonzero(pend_nz)
  );

  refsched_strobe #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC), .RAS_ONLY(RAS_ONLY)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  assign init_start = (phase_q == PH_INIT) && !busy && (issued_q != INIT_N);
  assign run_start  = (phase_q == PH_RUN) && !busy && pend_nz && ctrl_idle;
  assign start      = init_start || run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_WAIT;
      issued_q <= '0;
    end else begin
      if (init_start) issued_q <= issued_q + 1'b1;
      unique case (phase_q)
        PH_WAIT: if (wait_tick) phase_q <= PH_INIT;
        PH_INIT: if (done && issued_q == INIT_N) phase_q <= PH_RUN;
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign ref_req    = (phase_q == PH_RUN) && pend_nz;
  assign host_ready = (phase_q == PH_RUN) && !busy && !(pend_nz && ctrl_idle);
  assign ref_active = busy;

  generate
    if (RAS_ONLY) begin : g_row
      logic [ROW_BITS-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    row_q <= '0;
        else if (done) row_q <= row_q + 1'b1;
      end
      assign ref_addr = busy ? row_q : '0;
    end else begin : g_cbr
      assign ref_addr = '0;
    end
  endgenerate

  AST_NO_READY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RUN) |-> !host_ready); // R2
  AST_READY_NOT_DURING_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active |-> !host_ready); // R10
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && !ctrl_idle && !busy) |=> !busy); // R8
  AST_WE_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> we_n); // R5
endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int INIT_WAIT = 50;
  localparam int INIT_CYC  = 8;
  localparam int INT       = 200;
  localparam int MAXP      = 8;
  localparam int CSR       = 1;
  localparam int CHR       = 1;
  localparam int RASW      = 6;
  localparam int PRE_EXP   = 5;   // max(4, 11-6)
  localparam int RC        = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_idle = 1'b1;
  logic ref_req, host_ready, ref_active, ras_n, cas_n, we_n;
  logic [12:0] ref_addr;
  logic ro_req, ro_ready, ro_active, ro_ras_n, ro_cas_n, ro_we_n;
  logic [12:0] ro_addr;

  int checks = 0, errors = 0, cyc = 0;
  int ref_cnt = 0, first_cf = -1, t_cf = 0, t_rf = 0, t_rr = 0;
  bit have_rise = 0, ready_early = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, ro_prev_ras = 1'b1;
  int ro_idx = 0;

  always #5 clk = ~clk;

  refresh_sched #(.INIT_WAIT(INIT_WAIT), .INTERVAL(INT)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_idle(ctrl_idle), .ref_req(ref_req),
    .host_ready(host_ready), .ref_active(ref_active), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ref_addr(ref_addr)
  );

  refresh_sched #(.INIT_WAIT(INIT_WAIT), .INTERVAL(INT), .RAS_ONLY(1'b1)) uut_ro (
    .clk(clk), .rst_n(rst_n), .ctrl_idle(1'b1), .ref_req(ro_req),
    .host_ready(ro_ready), .ref_active(ro_active), .ras_n(ro_ras_n),
    .cas_n(ro_cas_n), .we_n(ro_we_n), .ref_addr(ro_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // strobe monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_ready && ref_cnt < INIT_CYC) ready_early = 1;
      if (prev_cas && !cas_n && ras_n) begin
        ref_cnt++;
        t_cf = cyc;
        if (first_cf < 0) first_cf = cyc;
      end
      if (prev_ras && !ras_n) begin
        chk(cyc - t_cf == CSR, "R3 cas lead", cyc - t_cf, CSR);
        chk(we_n == 1'b1, "R5 we high", we_n, 1);
        chk(ref_addr == 0, "R11 cbr addr", ref_addr, 0);
        chk(!host_ready && ref_active, "R10 ready during ref", host_ready, 0);
        if (have_rise) begin
          chk(cyc - t_rr >= PRE_EXP, "R6 precharge", cyc - t_rr, PRE_EXP);
          chk(cyc - t_rf >= RC, "R6 cycle", cyc - t_rf, RC);
        end
        t_rf = cyc;
      end
      if (!ras_n && !prev_cas && cas_n)
        chk(cyc - t_rf == CHR, "R4 cas hold", cyc - t_rf, CHR);
      if (!prev_ras && ras_n) begin
        chk(cyc - t_rf == RASW, "R6 ras width", cyc - t_rf, RASW);
        chk(!cas_n == 1'b0, "R4 cas high before ras rise", !cas_n, 0);
        t_rr = cyc;
        have_rise = 1;
      end
      if ((!ras_n || !cas_n) && !we_n) chk(0, "R5 we low in ref", we_n, 1);
      // row-only instance
      if (ro_prev_ras && !ro_ras_n) begin
        chk(ro_addr == 13'(ro_idx), "R11 row addr", ro_addr, ro_idx);
        ro_idx++;
      end
      if (!ro_cas_n) chk(0, "R11 cas in row-only", ro_cas_n, 1);
      prev_ras = ras_n;
      prev_cas = cas_n;
      ro_prev_ras = ro_ras_n;
    end
  end

  task automatic wait_ref_start();
    int c0 = ref_cnt;
    while (ref_cnt == c0) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!host_ready && !ref_req, "R1 ready/req low in reset", {host_ready, ref_req}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic t_init();
    while (!host_ready) @(negedge clk);
    chk(first_cf >= INIT_WAIT, "R1 settling pause", first_cf, INIT_WAIT);
    chk(ref_cnt == INIT_CYC, "R2 init refresh count", ref_cnt, INIT_CYC);
    chk(!ready_early, "R2 ready before init end", ready_early, 0);
    chk(!ref_active, "R2 init finished", ref_active, 0);
  endtask

  task automatic t_periodic();
    int c0;
    wait_ref_start();
    c0 = ref_cnt;
    repeat (5 * INT + 2) @(negedge clk);
    chk(ref_cnt - c0 == 5, "R7 refreshes per 5 intervals", ref_cnt - c0, 5);
  endtask

  task automatic t_page_open();
    int c0;
    wait_ref_start();
    repeat (20) @(negedge clk);
    @(posedge clk); #1 ctrl_idle = 1'b0;
    c0 = ref_cnt;
    repeat (3 * INT) @(negedge clk);
    chk(ref_cnt == c0, "R8 no refresh during open page", ref_cnt - c0, 0);
    chk(ref_req == 1'b1, "R8 ref_req while pending", ref_req, 1);
    chk(host_ready == 1'b1, "R8 host keeps page", host_ready, 1);
    @(posedge clk); #1 ctrl_idle = 1'b1;
    @(negedge clk);
    chk(host_ready == 1'b0, "R10 refresh wins over host", host_ready, 0);
    repeat (60) @(negedge clk);
    chk(ref_cnt - c0 == 3, "R8 postponed refreshes run", ref_cnt - c0, 3);
    chk(ref_req == 1'b0, "R8 ref_req drops", ref_req, 0);
  endtask

  task automatic t_saturate();
    int c0;
    wait_ref_start();
    repeat (20) @(negedge clk);
    @(posedge clk); #1 ctrl_idle = 1'b0;
    c0 = ref_cnt;
    repeat (12 * INT - 15) @(negedge clk);
    chk(ref_cnt == c0, "R9 held while page open", ref_cnt - c0, 0);
    @(posedge clk); #1 ctrl_idle = 1'b1;
    repeat (150) @(negedge clk);
    chk(ref_cnt - c0 == MAXP, "R9 saturated burst", ref_cnt - c0, MAXP);
    chk(ref_req == 1'b0 && host_ready == 1'b1, "R9 backlog cleared",
        {ref_req, host_ready}, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_init();
        t_periodic();
        t_page_open();
        t_saturate();
        chk(ro_idx > 10, "R11 row-only refreshes seen", ro_idx, 11);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule